// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block takes a dynamic memory module from power-up to normal operation and then keeps its contents alive. After reset it holds every strobe inactive for a configurable startup delay. It then runs a fixed number of warm-up refresh cycles without asking for the bus, because no other traffic is allowed yet. When these are done it raises `init_done`.

From then on a divider produces one refresh slot per row interval. The interval is the refresh window divided by the row count, converted to clock cycles. Each slot adds to a small backlog counter. While the backlog is non-zero, or a refresh cycle is running, the block asserts `refresh_req`. The access controller answers with `grant`, and the block runs one refresh cycle per backlog entry, back to back, for as long as the grant stays high.

Each refresh cycle has three phases:
- **Column-first lead:** all column strobes are pulled low before any row strobe.
- **Row-low:** the row strobes are held low for the required width.
- **Precharge:** all strobes return high for long enough to meet the minimum cycle time.

The write strobe stays high throughout. A build parameter instead selects row-only refresh. In that mode the column strobes never move, and the block drives its own row counter on the address pins.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset release until STARTUP_C clock edges have elapsed, every row and column strobe stays high. The first row strobe fall comes exactly two edges after the startup delay expires in column-first mode (one lead cycle).
- R2: After the startup delay, exactly INIT_REFRESHES refresh cycles run regardless of `grant`. `init_done` rises on the edge at which the last of them finishes its precharge.
- R3: After `init_done`, one refresh slot is produced every IVL_C cycles, where IVL_C = floor(REF_WINDOW_NS / REF_ROWS × CLK_MHZ / 1000). With `grant` held high, a window of 10 × IVL_C cycles contains exactly 10 refresh cycles.
- R4: In column-first mode, all column strobes (`cas_n`, active low) go low LEAD_C ≥ 1 cycles before the row strobes fall. They stay low for the whole row-low phase and return high with the row strobes.
- R5: The row-low phase lasts RAS_C cycles and precharge lasts PRE_C cycles, where each is the ceiling of its time limit in cycles. PRE_C is stretched so that the whole cycle is at least the minimum cycle time. `we_n` is always high.
- R6: After `init_done`, a refresh cycle starts only on an edge where `grant` is high. `refresh_req` equals `init_done` and (backlog non-zero or cycle in progress).
- R7: The backlog grows by one per refresh slot and shrinks by one per started cycle. It saturates at PEND_MAX (8), and a slot and a start on the same edge leave it unchanged. Queued cycles run back to back with no idle cycle between them.
- R8: With RAS_ONLY = 1, `cas_n` never goes low and there is no lead phase. `addr` carries a row counter that starts at 0 after reset, is valid while the row strobes are low, and increments modulo 2^ROW_W when the row strobes rise.
- R9: While reset is high, all strobes and `we_n` are high, and `refresh_req` and `init_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Bus granted to the refresh engine by the access controller |
| refresh_req | output | 1 | Refresh wanted or running |
| init_done | output | 1 | Power-up sequence complete, normal accesses allowed |
| ras_n | output | RAS_W | Row strobes, active low, all driven alike |
| cas_n | output | CAS_W | Column strobes, active low, all driven alike |
| we_n | output | 1 | Write strobe, held high |
| addr | output | ROW_W | Row address in row-only mode, zero otherwise |

## Verification
The two functions that can fall in the same cycle are the slot divider adding to the backlog and the sequencer removing from it when it starts a cycle. They also meet at the point where one cycle's last precharge cycle becomes the next cycle's lead.

These collisions are provoked in three ways:
- withholding `grant` for twelve intervals, so the backlog saturates;
- then granting while the backlog drains across several interval boundaries;
- later toggling `grant` out of phase with the interval.

A behavioural model built from a queue of scheduled strobe values and an integer backlog is compared against `ras_n`, `cas_n`, `we_n`, `refresh_req` and `init_done` on every clock. A lost or doubled slot, or a gap between back-to-back cycles, therefore shows up as a mismatch at the exact cycle it occurs.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_RASLO,
    SQ_PRE
  } seq_st_t;

  typedef enum logic [1:0] {
    PU_WAIT,
    PU_INIT,
    PU_RUN
  } pu_st_t;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_divider.sv
module dram_ref_divider #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R3
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int PEND_MAX = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          slot,
  input  logic                          take,
  output logic [$clog2(PEND_MAX+1)-1:0] count
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW:0] CAP = (PW+1)'(PEND_MAX);

  logic [PW:0] sum;

  always_comb begin
    sum = {1'b0, count} + (PW+1)'(slot) - (PW+1)'(take);
    if (sum > CAP) sum = CAP;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= sum[PW-1:0];
  end

  AST_PEND_CAP: assert property (@(posedge clk) disable iff (rst)
    {1'b0, count} <= CAP); // R7
  AST_PEND_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot && !take && ({1'b0, count} < CAP)) |=> (count == PW'($past(count) + 1'b1))); // R7
  AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (take && !slot) |=> (count == PW'($past(count) - 1'b1))); // R7
endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe
  import dram_ref_pkg::*;
#(
  parameter int LEAD_C   = 1,
  parameter int RAS_C    = 6,
  parameter int PRE_C    = 4,
  parameter int RAS_W    = 4,
  parameter int CAS_W    = 4,
  parameter int ROW_W    = 10,
  parameter bit RAS_ONLY = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             ready,
  output logic             busy,
  output logic [RAS_W-1:0] ras_n,
  output logic [CAS_W-1:0] cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row
);
  localparam int MAXC = imax(imax(LEAD_C, RAS_C), PRE_C);
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] LEAD_LAST = CW'((LEAD_C > 0) ? LEAD_C - 1 : 0);
  localparam logic [CW-1:0] RAS_LAST  = CW'(RAS_C - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_C - 1);

  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic          ras_q;
  logic          cas_q;
  logic          we_q;
  logic          ras_end;

  assign ready   = (st == SQ_IDLE) || ((st == SQ_PRE) && (cnt == PRE_LAST));
  assign busy    = (st != SQ_IDLE);
  assign ras_end = (st == SQ_RASLO) && (cnt == RAS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else if (start && ready) begin
      cnt <= '0;
      if (LEAD_C > 0) begin
        st    <= SQ_LEAD;
        cas_q <= 1'b0;
        ras_q <= 1'b1;
      end else begin
        st    <= SQ_RASLO;
        ras_q <= 1'b0;
        cas_q <= 1'b1;
      end
    end else begin
      unique case (st)
        SQ_LEAD: begin
          if (cnt == LEAD_LAST) begin
            st    <= SQ_RASLO;
            cnt   <= '0;
            ras_q <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_RASLO: begin
          if (ras_end) begin
            st    <= SQ_PRE;
            cnt   <= '0;
            ras_q <= 1'b1;
            cas_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_PRE: begin
          if (cnt == PRE_LAST) begin
            st  <= SQ_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st  <= SQ_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= 1'b1;
  end

  generate
    if (RAS_ONLY) begin : g_rowctr
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk) begin
        if (rst)          row_q <= '0;
        else if (ras_end) row_q <= row_q + 1'b1;
      end
      assign row = row_q;

      AST_NO_CAS_ROWONLY: assert property (@(posedge clk) disable iff (rst)
        cas_q); // R8
      AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_q) |-> (row == ROW_W'($past(row) + 1'b1))); // R8
    end else begin : g_norow
      assign row = '0;

      AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_q) |-> (!cas_q && $past(!cas_q))); // R4
      AST_CAS_HELD: assert property (@(posedge clk) disable iff (rst)
        !ras_q |-> !cas_q); // R4
    end
  endgenerate

  assign ras_n = {RAS_W{ras_q}};
  assign cas_n = {CAS_W{cas_q}};
  assign we_n  = we_q;

  AST_PRE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_PRE) |-> (ras_q && cas_q)); // R5
  AST_RAS_MIN: assert property (@(posedge clk) disable iff (rst)
    ($rose(ras_q) && (RAS_C > 1)) |-> $past(!ras_q, 2)); // R5
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ        = 100,
  parameter int T_STARTUP_NS   = 200000,
  parameter int INIT_REFRESHES = 8,
  parameter int REF_WINDOW_NS  = 16000000,
  parameter int REF_ROWS       = 1024,
  parameter int T_CSR_NS       = 5,
  parameter int T_CHR_NS       = 10,
  parameter int T_RAS_NS       = 60,
  parameter int T_RP_NS        = 40,
  parameter int T_RC_NS        = 110,
  parameter int PEND_MAX       = 8,
  parameter int RAS_W          = 4,
  parameter int CAS_W          = 4,
  parameter int ROW_W          = 10,
  parameter bit RAS_ONLY       = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  output logic             refresh_req,
  output logic             init_done,
  output logic [RAS_W-1:0] ras_n,
  output logic [CAS_W-1:0] cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);
  localparam int STARTUP_C = imax(1, ns2cyc(T_STARTUP_NS, CLK_MHZ));
  localparam int IVL_C     = imax(2, (REF_WINDOW_NS / REF_ROWS) * CLK_MHZ / 1000);
  localparam int LEAD_C    = RAS_ONLY ? 0 : imax(1, ns2cyc(T_CSR_NS, CLK_MHZ));
  localparam int RAS_C     = imax(1, imax(ns2cyc(T_RAS_NS, CLK_MHZ),
                                          RAS_ONLY ? 0 : ns2cyc(T_CHR_NS, CLK_MHZ)));
  localparam int PRE_C     = imax(imax(1, ns2cyc(T_RP_NS, CLK_MHZ)),
                                  ns2cyc(T_RC_NS, CLK_MHZ) - LEAD_C - RAS_C);
  localparam int IW        = $clog2(INIT_REFRESHES + 1);
  localparam int PW        = $clog2(PEND_MAX + 1);

  pu_st_t        st;
  logic [IW-1:0] init_left;
  logic          done_q;
  logic          wait_over;
  logic          slot;
  logic [PW-1:0] backlog;
  logic          seq_ready;
  logic          seq_busy;
  logic          start_init;
  logic          start_run;
  logic          start;

  dram_ref_divider #(.LIMIT(STARTUP_C)) u_startup (
    .clk (clk),
    .rst (rst),
    .en  (st == PU_WAIT),
    .tick(wait_over)
  );

  dram_ref_divider #(.LIMIT(IVL_C)) u_interval (
    .clk (clk),
    .rst (rst),
    .en  (st == PU_RUN),
    .tick(slot)
  );

  dram_ref_backlog #(.PEND_MAX(PEND_MAX)) u_backlog (
    .clk  (clk),
    .rst  (rst),
    .slot (slot),
    .take (start_run),
    .count(backlog)
  );

  assign start_init = (st == PU_INIT) && seq_ready && (init_left != '0);
  assign start_run  = (st == PU_RUN) && seq_ready && (backlog != '0) && grant;
  assign start      = start_init || start_run;

  dram_ref_strobe #(
    .LEAD_C  (LEAD_C),
    .RAS_C   (RAS_C),
    .PRE_C   (PRE_C),
    .RAS_W   (RAS_W),
    .CAS_W   (CAS_W),
    .ROW_W   (ROW_W),
    .RAS_ONLY(RAS_ONLY)
  ) u_strobe (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .ready(seq_ready),
    .busy (seq_busy),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .row  (addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PU_WAIT;
      init_left <= IW'(INIT_REFRESHES);
      done_q    <= 1'b0;
    end else begin
      unique case (st)
        PU_WAIT: if (wait_over) st <= PU_INIT;
        PU_INIT: begin
          if (start_init) begin
            init_left <= init_left - 1'b1;
          end else if (seq_ready && (init_left == '0)) begin
            st     <= PU_RUN;
            done_q <= 1'b1;
          end
        end
        default: st <= PU_RUN;
      endcase
    end
  end

  assign init_done   = done_q;
  assign refresh_req = done_q && ((backlog != '0) || seq_busy);

  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == PU_WAIT) |-> ((&ras_n) && (&cas_n))); // R1
  AST_INIT_COUNTED: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (init_left == '0)); // R2
  AST_GRANTED_START: assert property (@(posedge clk) disable iff (rst)
    (init_done && $rose(seq_busy)) |-> $past(grant)); // R6
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (init_done && !(&ras_n)) |-> refresh_req); // R6
endmodule

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
  localparam int CLK_MHZ  = 100;
  localparam int STARTUP  = 300;
  localparam int WINDOW   = 409600;
  localparam int ROWS     = 1024;
  localparam int S_C      = 30;   // 300 ns at 100 MHz
  localparam int IVL      = 40;   // 400 ns per slot
  localparam int L_C      = 1;
  localparam int R_C      = 6;
  localparam int P_C      = 4;
  localparam int N_C      = L_C + R_C + P_C;
  localparam int INIT_N   = 8;
  localparam int PMAX     = 8;
  localparam int ROW1_W   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 1'b0;
  logic grant1 = 1'b1;
  always #5 clk = ~clk;

  logic       req0, done0, we0;
  logic [3:0] ras0, cas0;
  logic [9:0] addr0;
  logic       req1, done1, we1;
  logic [3:0] ras1, cas1;
  logic [ROW1_W-1:0] addr1;

  dram_refresh_seq #(.CLK_MHZ(CLK_MHZ), .T_STARTUP_NS(STARTUP), .INIT_REFRESHES(INIT_N),
    .REF_WINDOW_NS(WINDOW), .REF_ROWS(ROWS)) u0 (
    .clk(clk), .rst(rst), .grant(grant), .refresh_req(req0), .init_done(done0),
    .ras_n(ras0), .cas_n(cas0), .we_n(we0), .addr(addr0));

  dram_refresh_seq #(.CLK_MHZ(CLK_MHZ), .T_STARTUP_NS(STARTUP), .INIT_REFRESHES(INIT_N),
    .REF_WINDOW_NS(WINDOW), .REF_ROWS(ROWS), .ROW_W(ROW1_W), .RAS_ONLY(1'b1)) u1 (
    .clk(clk), .rst(rst), .grant(grant1), .refresh_req(req1), .init_done(done1),
    .ras_n(ras1), .cas_n(cas1), .we_n(we1), .addr(addr1));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // ---------------- behavioural reference for u0 ----------------
  int m_st, m_cnt, m_left, m_pend, m_ivl;
  bit m_done;
  logic [1:0] m_q[$];   // bit0 ras level, bit1 cas level
  bit e_ras = 1'b1, e_cas = 1'b1, e_busy = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_left = INIT_N; m_pend = 0; m_ivl = 0; m_done = 1'b0;
      m_q.delete();
      e_ras = 1'b1; e_cas = 1'b1; e_busy = 1'b0;
    end else begin
      bit ready, st_go, tk;
      logic [1:0] v;
      ready = (m_q.size() == 0);
      st_go = 1'b0;
      tk = 1'b0;
      case (m_st)
        0: if (m_cnt == S_C - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
        1: if (ready) begin
             if (m_left > 0) begin st_go = 1'b1; m_left--; end
             else begin m_st = 2; m_done = 1'b1; end
           end
        default: begin
          tk = (m_ivl == IVL - 1);
          m_ivl = tk ? 0 : m_ivl + 1;
          st_go = ready && (m_pend > 0) && grant;
          m_pend = m_pend + int'(tk) - int'(st_go);
          if (m_pend > PMAX) m_pend = PMAX;
        end
      endcase
      if (st_go) begin
        for (int i = 0; i < L_C; i++) m_q.push_back(2'b01);
        for (int i = 0; i < R_C; i++) m_q.push_back(2'b00);
        for (int i = 0; i < P_C; i++) m_q.push_back(2'b11);
      end
      if (m_q.size() > 0) begin
        v = m_q.pop_front();
        e_ras = v[0]; e_cas = v[1]; e_busy = 1'b1;
      end else begin
        e_ras = 1'b1; e_cas = 1'b1; e_busy = 1'b0;
      end
    end
  end

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  // ---------------- per-clock comparison and edge logging ----------------
  int falls0[$];
  int exp_row1 = 0;
  logic prev_ras0 = 1'b1, prev_ras1 = 1'b1;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(ras0 == {4{e_ras}}, "R5", "row strobes vs model", int'(ras0), int'({4{e_ras}}));
      chk(cas0 == {4{e_cas}}, "R4", "column strobes vs model", int'(cas0), int'({4{e_cas}}));
      chk(we0 == 1'b1, "R5", "write strobe", int'(we0), 1);
      chk(done0 == m_done, "R2", "init_done vs model", int'(done0), int'(m_done));
      chk(req0 == (m_done && (m_pend > 0 || e_busy)), "R6", "refresh_req vs model",
          int'(req0), int'(m_done && (m_pend > 0 || e_busy)));
      chk(cas1 == 4'hF, "R8", "row-only column strobes", int'(cas1), 15);
      if (prev_ras0 && !ras0[0]) falls0.push_back(cyc);
      if (prev_ras1 && !ras1[0]) begin
        chk(addr1 == ROW1_W'(exp_row1), "R8", "row-only address", int'(addr1), exp_row1 % (1 << ROW1_W));
        exp_row1++;
      end
      prev_ras0 = ras0[0];
      prev_ras1 = ras1[0];
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    wrap_up();
  end

  // ---------------- stimulus ----------------
  initial begin
    int f0;
    int good;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(ras0 == 4'hF && cas0 == 4'hF && we0, "R9", "strobes in reset", int'({ras0, cas0}), 255);
    chk(!req0 && !done0, "R9", "req/done in reset", int'({req0, done0}), 0);
    rst = 1'b0;

    // R1 / R2: grant held low throughout power-up
    while (!done0) @(negedge clk);
    chk(cyc == S_C + INIT_N * N_C + 1, "R2", "init_done cycle", cyc, S_C + INIT_N * N_C + 1);
    chk(falls0.size() == INIT_N, "R2", "warm-up refresh count", falls0.size(), INIT_N);
    chk(falls0[0] == S_C + 1 + L_C, "R1", "first row strobe fall", falls0[0], S_C + 1 + L_C);
    chk(falls0[1] - falls0[0] == N_C, "R5", "cycle length", falls0[1] - falls0[0], N_C);

    // R6 / R7: no grant for twelve slots
    f0 = falls0.size();
    repeat (12 * IVL) @(negedge clk);
    chk(falls0.size() == f0, "R6", "no cycle without grant", falls0.size(), f0);
    chk(req0 == 1'b1, "R6", "request held", int'(req0), 1);

    // R7: saturated backlog drains back to back
    grant = 1'b1;
    f0 = falls0.size();
    repeat (PMAX * N_C + 5) @(negedge clk);
    chk(falls0.size() - f0 >= PMAX, "R7", "burst length", falls0.size() - f0, PMAX);
    good = 0;
    for (int k = f0; k < f0 + PMAX - 1; k++)
      if (falls0[k + 1] - falls0[k] == N_C) good++;
    chk(good == PMAX - 1, "R7", "back-to-back gaps", good, PMAX - 1);
    while (req0) @(negedge clk);
    chk(falls0.size() - f0 < 12, "R7", "backlog capped", falls0.size() - f0, PMAX + 3);

    // R3: steady grant, ten slots in ten intervals
    f0 = falls0.size();
    repeat (10 * IVL) @(negedge clk);
    chk(falls0.size() - f0 == 10, "R3", "slots per window", falls0.size() - f0, 10);
    chk(falls0[falls0.size() - 1] - falls0[falls0.size() - 2] == IVL, "R3", "slot spacing",
        falls0[falls0.size() - 1] - falls0[falls0.size() - 2], IVL);

    // R6 / R7: grant toggling out of phase with the slot divider
    for (int i = 0; i < 60; i++) begin
      grant = ~grant;
      repeat (13) @(negedge clk);
    end
    grant = 1'b1;
    repeat (3 * IVL) @(negedge clk);
    chk(exp_row1 > (1 << ROW1_W), "R8", "row counter wrapped", exp_row1, (1 << ROW1_W) + 1);
    wrap_up();
  end
endmodule